// File: doc/BRIEF.md
# Priority Interrupt Request Core

This block collects eight asynchronous interrupt request lines and turns them into one interrupt output to a processor. It synchronizes each line into the core clock domain. It latches requests in a pending register, either on a rising edge or on a high level. It removes masked levels and compares the best remaining request against the levels already being serviced. The interrupt output rises only when a new request outranks all work in progress. Level 0 has the highest priority and level 7 the lowest.

The processor answers with a train of acknowledge strobes, each one clock wide. The sequence has two or three strobes, chosen by a mode input. The first strobe picks the winning level and moves it from pending to in-service. If the request has disappeared by then, level 7 is reported in its place. An in-service bit is cleared in one of two ways. In automatic mode it clears on the last strobe of the sequence. Otherwise it stays set until a non-specific end-of-service pulse arrives. Mask and mode settings come from a separate register file. Command decoding and vector formatting belong to neighbouring blocks.

Top module: `pirq_core`

## Requirements
- R1: A synchronous reset clears the pending register, the in-service register, `svc_level` and `int_out`.
- R2: With `level_mode`=0, a pending bit is set three clocks after its line rises. It clears if the line falls before acknowledge. A line that stays high after acknowledge raises no new request.
- R3: With `level_mode`=1, each pending bit follows the synchronized level of its line. After the bit is committed, it is set again while the line stays high.
- R4: A `mask` bit of 1 keeps its level from raising `int_out` and from winning. Other levels are not affected.
- R5: Priority is fixed: a lower bit index outranks a higher one, so bit 0 is highest.
- R6: `int_out` is 1 exactly when some unmasked pending bit has a lower index than every set in-service bit. An empty in-service register counts as no limit.
- R7: On the first `ack` strobe of a sequence, the winning level's in-service bit is set and its pending bit is cleared. `svc_level` takes the winner's index.
- R8: If no level qualifies under R6 at the first strobe, `svc_level` becomes 7 and in-service bit 7 is set.
- R9: With `auto_eoi`=1, the in-service bit of `svc_level` clears on the final strobe and not earlier. The final strobe is the 3rd when `two_pulse`=0 and the 2nd when `two_pulse`=1.
- R10: With `auto_eoi`=0, in-service bits stay set until an `eoi` pulse. Each `eoi` pulse clears the lowest-index set in-service bit.
- R11: After the final strobe, the next `ack` starts a new sequence as a first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous request lines, bit i is level i |
| level_mode | input | 1 | 1 = level triggered, 0 = edge triggered |
| auto_eoi | input | 1 | 1 = clear in-service on the final strobe |
| two_pulse | input | 1 | 1 = two-strobe sequence, 0 = three-strobe |
| mask | input | 8 | 1 = level blocked |
| ack | input | 1 | Acknowledge strobe, one clock per pulse |
| eoi | input | 1 | Non-specific end-of-service pulse |
| int_out | output | 1 | Interrupt to the processor |
| svc_level | output | 3 | Level committed at the last first strobe |
| irr_q | output | 8 | Pending request register |
| isr_q | output | 8 | In-service register |

## Verification
The hardest case to reach is a spurious acknowledge. A request must raise `int_out` and then vanish before the first strobe. To get there, the stimulus raises a line, waits until the pending bit appears, and drops the line again. It checks that the bit has cleared before sending the strobe train. Nested service is also built up on purpose. A low-priority level is held in service while a lower-priority line and then a higher-priority line are raised. Repeated `eoi` pulses then unwind the stack. A sweep runs over all 255 request patterns under three masks, alternating the two- and three-strobe sequences.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NLVL = 8;
    localparam int LW   = $clog2(NLVL);

    typedef logic [NLVL-1:0] lvl_vec_t;
    typedef logic [LW-1:0]   lvl_idx_t;
    typedef logic [1:0]      pulse_cnt_t;

    typedef struct packed {
        logic     vld;
        lvl_idx_t idx;
    } pick_t;

    localparam lvl_idx_t SPURIOUS_IDX = lvl_idx_t'(NLVL - 1);

    function automatic pick_t first_set(input lvl_vec_t v);
        pick_t r;
        r.vld = 1'b0;
        r.idx = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.vld = 1'b1;
                r.idx = lvl_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic lvl_vec_t onehot(input lvl_idx_t i);
        lvl_vec_t r;
        r = '0;
        r[i] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pirq_linein.sv
module pirq_linein #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sh;
    logic                   prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[SYNC_STAGES-2:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sh[SYNC_STAGES-1];
    end

    assign lvl  = sh[SYNC_STAGES-1];
    assign rise = sh[SYNC_STAGES-1] & ~prev;
endmodule

// File: rtl/pirq_resolve.sv
module pirq_resolve
    import pirq_pkg::*;
(
    input  lvl_vec_t irr,
    input  lvl_vec_t isr,
    input  lvl_vec_t mask,
    output logic     int_req,
    output lvl_idx_t win_idx
);
    pick_t p_pend;
    pick_t p_svc;

    always_comb begin
        p_pend  = first_set(irr & ~mask);
        p_svc   = first_set(isr);
        int_req = p_pend.vld && (!p_svc.vld || (p_pend.idx < p_svc.idx));
        win_idx = p_pend.idx;
    end
endmodule

// File: rtl/pirq_service.sv
module pirq_service
    import pirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack,
    input  logic     eoi,
    input  logic     auto_eoi,
    input  logic     two_pulse,
    input  logic     int_req,
    input  lvl_idx_t win_idx,
    output lvl_vec_t isr,
    output lvl_idx_t svc_level,
    output lvl_vec_t irr_clr
);
    pulse_cnt_t cnt;
    pulse_cnt_t last;
    logic       first_p;
    logic       final_p;
    lvl_idx_t   pick;
    lvl_vec_t   set_v;
    lvl_vec_t   eoi_clr;
    lvl_vec_t   aeoi_clr;
    pick_t      top_svc;

    always_comb begin
        last     = two_pulse ? pulse_cnt_t'(1) : pulse_cnt_t'(2);
        first_p  = ack && (cnt == '0);
        final_p  = ack && (cnt == last);
        pick     = int_req ? win_idx : SPURIOUS_IDX;
        set_v    = first_p ? onehot(pick) : '0;
        irr_clr  = (first_p && int_req) ? onehot(win_idx) : '0;
        top_svc  = first_set(isr);
        eoi_clr  = (eoi && top_svc.vld) ? onehot(top_svc.idx) : '0;
        aeoi_clr = (final_p && auto_eoi) ? onehot(svc_level) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            isr       <= '0;
            svc_level <= '0;
        end else begin
            isr <= (isr & ~eoi_clr & ~aeoi_clr) | set_v;
            if (first_p) svc_level <= pick;
            if (ack) begin
                if (final_p) cnt <= '0;
                else         cnt <= cnt + pulse_cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/pirq_core.sv
module pirq_core
    import pirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       level_mode,
    input  logic       auto_eoi,
    input  logic       two_pulse,
    input  logic [7:0] mask,
    input  logic       ack,
    input  logic       eoi,
    output logic       int_out,
    output logic [2:0] svc_level,
    output logic [7:0] irr_q,
    output logic [7:0] isr_q
);
    lvl_vec_t lvl;
    lvl_vec_t rise;
    lvl_vec_t irr;
    lvl_vec_t isr;
    lvl_vec_t irr_clr;
    lvl_vec_t irr_nxt;
    logic     int_req;
    lvl_idx_t win_idx;

    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_line
            pirq_linein #(.SYNC_STAGES(SYNC_STAGES)) u_line (
                .clk (clk),
                .rst (rst),
                .raw (irq_in[g]),
                .lvl (lvl[g]),
                .rise(rise[g])
            );
        end
    endgenerate

    always_comb begin
        if (level_mode) irr_nxt = lvl & ~irr_clr;
        else            irr_nxt = (rise | (irr & lvl)) & ~irr_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) irr <= '0;
        else     irr <= irr_nxt;
    end

    pirq_resolve u_resolve (
        .irr    (irr),
        .isr    (isr),
        .mask   (mask),
        .int_req(int_req),
        .win_idx(win_idx)
    );

    pirq_service u_service (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .eoi      (eoi),
        .auto_eoi (auto_eoi),
        .two_pulse(two_pulse),
        .int_req  (int_req),
        .win_idx  (win_idx),
        .isr      (isr),
        .svc_level(svc_level),
        .irr_clr  (irr_clr)
    );

    assign int_out = int_req;
    assign irr_q   = irr;
    assign isr_q   = isr;
endmodule

// File: rtl/pirq_core_chk.sv
module pirq_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       auto_eoi,
    input logic       two_pulse,
    input logic [7:0] mask,
    input logic       ack,
    input logic       eoi,
    input logic       int_out,
    input logic [2:0] svc_level,
    input logic [7:0] irr_q,
    input logic [7:0] isr_q
);
    logic [1:0] ck_cnt;
    logic [1:0] ck_last;

    assign ck_last = two_pulse ? 2'd1 : 2'd2;

    always_ff @(posedge clk) begin
        if (rst)      ck_cnt <= 2'd0;
        else if (ack) ck_cnt <= (ck_cnt == ck_last) ? 2'd0 : ck_cnt + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (irr_q == 8'h00 && isr_q == 8'h00 && !int_out));

    a_r4_int_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr_q & ~mask) != 8'h00));

    a_r7_commit_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (ack && ck_cnt == 2'd0 && !eoi) |=> isr_q[svc_level]);

    a_r9_aeoi_final_clear: assert property (@(posedge clk) disable iff (rst)
        (ack && ck_cnt == ck_last && ck_cnt != 2'd0 && auto_eoi) |=> !isr_q[$past(svc_level)]);

    a_r10_isr_holds: assert property (@(posedge clk) disable iff (rst)
        (!eoi && !auto_eoi) |=> (($past(isr_q) & ~isr_q) == 8'h00));
endmodule

bind pirq_core pirq_core_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .auto_eoi (auto_eoi),
    .two_pulse(two_pulse),
    .mask     (mask),
    .ack      (ack),
    .eoi      (eoi),
    .int_out  (int_out),
    .svc_level(svc_level),
    .irr_q    (irr_q),
    .isr_q    (isr_q)
);

// File: tb/test_pirq_core.sv
module test_pirq_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       level_mode = 1'b0;
    logic       auto_eoi = 1'b0;
    logic       two_pulse = 1'b0;
    logic [7:0] mask = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       int_out;
    logic [2:0] svc_level;
    logic [7:0] irr_q;
    logic [7:0] isr_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pirq_core i_pirq_core (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(level_mode),
        .auto_eoi(auto_eoi), .two_pulse(two_pulse), .mask(mask), .ack(ack),
        .eoi(eoi), .int_out(int_out), .svc_level(svc_level),
        .irr_q(irr_q), .isr_q(isr_q)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    function automatic logic [2:0] lowbit(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
        return 3'd7;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] masks [3];
        masks[0] = 8'h00; masks[1] = 8'h81; masks[2] = 8'h3C;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        chk("R1 irr", irr_q, 8'h00);
        chk("R1 isr", isr_q, 8'h00);
        chk("R1 int", {7'd0, int_out}, 8'h00);
        chk("R1 svc", {5'd0, svc_level}, 8'h00);

        // Sweep: R4 R5 R6 R7 R8 R9 R11 in edge mode with automatic clear
        auto_eoi = 1'b1;
        for (int mi = 0; mi < 3; mi++) begin
            for (int p = 1; p < 256; p++) begin
                logic [7:0] pend, wv;
                logic [2:0] w;
                logic       ok;
                int         npl;
                mask = masks[mi];
                two_pulse = p[0];
                npl = two_pulse ? 2 : 3;
                pend = 8'(p) & ~mask;
                ok = (pend != 0);
                w = ok ? lowbit(pend) : 3'd7;
                wv = 8'(1) << w;
                irq_in = 8'(p);
                wait_n(4);
                chk("R2 irr set", irr_q, 8'(p));
                chk("R6 int", {7'd0, int_out}, {7'd0, ok});
                do_ack();
                chk(ok ? "R5 svc" : "R8 svc", {5'd0, svc_level}, {5'd0, w});
                chk("R7 isr", isr_q, wv);
                chk("R7 irr", irr_q, ok ? (8'(p) & ~wv) : 8'(p));
                for (int k = 1; k < npl; k++) begin
                    if (k == npl - 1) begin
                        do_ack();
                        chk("R9 final clear", isr_q, 8'h00);
                    end else begin
                        do_ack();
                        chk("R9 not early", isr_q, wv);
                    end
                end
                chk("R6 int after", {7'd0, int_out},
                    {7'd0, ((pend & ~(ok ? wv : 8'h00)) != 0)});
                irq_in = 8'h00;
                wait_n(4);
                chk("R2 drop clears", irr_q, 8'h00);
            end
        end
        mask = 8'h00;

        // Nested service, R6 R10 R2 (three-strobe, no auto clear)
        auto_eoi = 1'b0; two_pulse = 1'b0;
        irq_in = 8'h08; wait_n(4);
        do_ack(); do_ack(); do_ack();
        chk("R7 nest svc", {5'd0, svc_level}, 8'd3);
        chk("R10 nest isr", isr_q, 8'h08);
        irq_in = 8'h28; wait_n(4);
        chk("R6 lower blocked", {7'd0, int_out}, 8'h00);
        chk("R2 held no rerequest", irr_q, 8'h20);
        irq_in = 8'h2A; wait_n(4);
        chk("R6 higher passes", {7'd0, int_out}, 8'h01);
        do_ack(); do_ack(); do_ack();
        chk("R7 nest svc2", {5'd0, svc_level}, 8'd1);
        chk("R10 stacked isr", isr_q, 8'h0A);
        wait_n(5);
        chk("R10 isr holds", isr_q, 8'h0A);
        do_eoi();
        chk("R10 eoi top", isr_q, 8'h08);
        do_eoi();
        chk("R10 eoi next", isr_q, 8'h00);
        chk("R6 pending 5", {7'd0, int_out}, 8'h01);
        do_ack(); do_ack(); do_ack();
        chk("R7 svc5", {5'd0, svc_level}, 8'd5);
        chk("R2 held lines idle", irr_q, 8'h00);
        do_eoi();
        irq_in = 8'h00; wait_n(4);

        // Level mode R3
        level_mode = 1'b1;
        irq_in = 8'h10; wait_n(4);
        chk("R3 level irr", irr_q, 8'h10);
        do_ack(); do_ack(); do_ack();
        chk("R3 isr", isr_q, 8'h10);
        wait_n(2);
        chk("R3 reload", irr_q, 8'h10);
        chk("R6 same level blocked", {7'd0, int_out}, 8'h00);
        irq_in = 8'h00; wait_n(4);
        chk("R3 level drop", irr_q, 8'h00);
        do_eoi();
        chk("R10 level eoi", isr_q, 8'h00);
        level_mode = 1'b0;

        // Spurious R8
        irq_in = 8'h04; wait_n(4);
        chk("R2 pre spur", {7'd0, int_out}, 8'h01);
        irq_in = 8'h00; wait_n(4);
        chk("R2 vanished", irr_q, 8'h00);
        do_ack(); do_ack(); do_ack();
        chk("R8 svc7", {5'd0, svc_level}, 8'd7);
        chk("R8 isr7", isr_q, 8'h80);
        do_eoi();
        chk("R10 spur eoi", isr_q, 8'h00);

        // Two-strobe restart R11
        two_pulse = 1'b1;
        irq_in = 8'h01; wait_n(4);
        do_ack(); do_ack();
        chk("R11 svc0", {5'd0, svc_level}, 8'd0);
        do_eoi();
        irq_in = 8'h03; wait_n(4);
        do_ack();
        chk("R11 new first", {5'd0, svc_level}, 8'd1);
        chk("R11 isr", isr_q, 8'h02);
        do_ack();
        do_eoi();
        chk("R10 end", isr_q, 8'h00);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule